// File: doc/BRIEF.md
# Stack Call-Return Sequencer

This block carries out the stack and control-transfer part of a word-addressed processor. It takes the five operations that touch the stack pointer or redirect the program counter: push, pop, subroutine call, subroutine return and plain jump. It owns the stack pointer register. It makes single-word accesses to data memory, and it reports a new program counter or a register write when the operation calls for one. Instruction fetch and the register file stay outside. The core hands over the register operand value and the immediate word, and it takes back the write port.

Commands arrive on a valid/ready channel. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_valid` is high and `cmd_ready` is low, the sender keeps every command field unchanged. `cmd_ready` is high only while the sequencer is idle. It drops in the cycle after a command is taken and comes back in the cycle after `done`. The block latches all command fields when it takes the command, so the sender may present its next command while the current one runs.

The stack grows toward lower addresses. A push stores at the address in SP and then moves SP down by one. A pop or a return first moves SP up and then reads from the new SP. Memory is a plain synchronous port with no stall: at most one of `mem_we` and `mem_re` is high in any cycle, and read data is valid on `mem_rdata` in the cycle after `mem_re`.

Top module: `scr_unit`

## Requirements
- R1: After reset, `sp_o` equals the parameter SP_TOP, `cmd_ready` is 1, and `done`, `mem_we`, `mem_re`, `pc_we` and `rf_we` are 0.
- R2: PUSH is opcode 14. In the cycle after it is taken, the block drives `mem_we` with `mem_addr` equal to SP, and it raises `done` in the same cycle. SP is one lower in the cycle after that.
- R3: The PUSH value is `cmd_reg` when extension bit 0 is 0, and `cmd_imm` when extension bit 0 is 1.
- R4: POP is opcode 15. In the cycle after it is taken, the block drives `mem_re` at address SP+1, and SP takes that address. In the next cycle it drives `rf_we` with `rf_idx` equal to the latched `cmd_f1` and `rf_wdata` equal to `mem_rdata`, together with `done`.
- R5: Opcodes 12 and 13 with extension bit 0 clear are RET. RET reads memory at SP + `cmd_f1` + 1, and SP takes that address. In the next cycle `pc_we` is raised and `pc_new` is loaded from the low address bits of the read word, together with `done`.
- R6: Opcodes 12 and 13 with extension bit 0 set and bit 1 clear are JMP. In the cycle after the jump is taken, `pc_we` and `done` are raised. The target is the low bits of `cmd_reg` when extension bit 2 is 0, and of `cmd_imm` when it is 1. There is no memory access and SP is unchanged.
- R7: Opcodes 12 and 13 with extension bits 0 and 1 set are CALL. CALL stores a return address at SP, decrements SP, and raises `pc_we` with the target selected as for JMP, all in the cycle after it is taken.
- R8: With a register target (extension bit 2 = 0), CALL stores `cmd_pc`. With an immediate target it stores `cmd_pc`+1, which is the word after the immediate.
- R9: `cmd_ready` is low from the cycle after acceptance through the `done` cycle. A command presented in that time is not taken and does not change the running operation. It is taken after `done`.
- R10: Any other opcode completes with `done` one cycle after it is taken, with no memory access and no change to SP, PC or registers.
- R11: `mem_we` and `mem_re` are never high together, and each command makes at most one memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 7 | Opcode |
| cmd_ext | input | 8 | Extension bits (bit 0, 1, 2 as in the requirements) |
| cmd_f1 | input | 5 | POP destination index, or RET discard count |
| cmd_reg | input | W | Register operand value |
| cmd_imm | input | W | Immediate word following the instruction |
| cmd_pc | input | AW | Address of the word after the opcode word |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data, valid the cycle after `mem_re` |
| sp_o | output | AW | Current stack pointer |
| pc_we | output | 1 | Program counter load strobe |
| pc_new | output | AW | New program counter value |
| rf_we | output | 1 | Register write strobe (POP) |
| rf_idx | output | 5 | Register index to write |
| rf_wdata | output | W | Register write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The main patterns are push sequences of register and immediate values followed by pops. Reading the values back in reverse order shows the decrement-after-store and increment-before-load order, and a swapped order would return the wrong word. Calls with register and immediate targets, each followed by a zero-count return, tell apart the two return addresses (`cmd_pc` against `cmd_pc`+1). A return with a count of one over two pushed words shows that the discard count is added before the final increment. A new command held on the channel during a pop shows that fields latched at acceptance keep the operation steady, and that the waiting command runs only after `done`.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int unsigned OPW  = 7;
  localparam int unsigned EXTW = 8;
  localparam int unsigned IDXW = 5;

  localparam logic [OPW-1:0] OP_PUSH = 7'd14;
  localparam logic [OPW-1:0] OP_POP  = 7'd15;
  localparam logic [OPW-2:0] OP_FLOW = 6'd6;   // opcodes 12 and 13

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_PUSH,
    ACT_POP,
    ACT_RET,
    ACT_JMP,
    ACT_CALL
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_RWAIT
  } state_e;

endpackage

// File: rtl/scr_decode.sv
module scr_decode
  import scr_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 16
) (
  input  logic [OPW-1:0]  op,
  input  logic [EXTW-1:0] ext,
  input  logic [W-1:0]    reg_val,
  input  logic [W-1:0]    imm_val,
  input  logic [AW-1:0]   pc_val,
  output act_e            act,
  output logic [W-1:0]    store_val,
  output logic [AW-1:0]   target
);

  logic use_imm_data;
  logic use_imm_tgt;
  logic [AW-1:0] ret_addr;

  assign use_imm_data = ext[0];
  assign use_imm_tgt  = ext[2];

  always_comb begin
    act = ACT_NONE;
    if (op == OP_PUSH) begin
      act = ACT_PUSH;
    end else if (op == OP_POP) begin
      act = ACT_POP;
    end else if (op[OPW-1:1] == OP_FLOW) begin
      if (!ext[0])      act = ACT_RET;
      else if (!ext[1]) act = ACT_JMP;
      else              act = ACT_CALL;
    end
  end

  // return point: skip the immediate word when the target came from it
  assign ret_addr = use_imm_tgt ? pc_val + AW'(1) : pc_val;
  assign target   = use_imm_tgt ? imm_val[AW-1:0] : reg_val[AW-1:0];

  always_comb begin
    store_val = '0;
    if (act == ACT_CALL) store_val = W'(ret_addr);
    else                 store_val = use_imm_data ? imm_val : reg_val;
  end

endmodule

// File: rtl/scr_sp.sv
module scr_sp #(
  parameter int unsigned AW     = 16,
  parameter int unsigned CW     = 5,
  parameter logic [AW-1:0] SP_TOP = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec,
  input  logic          up,
  input  logic [CW:0]   up_amt,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_up_val
);

  assign sp_up_val = sp + AW'(up_amt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp <= SP_TOP;
    else if (dec) sp <= sp - AW'(1);
    else if (up)  sp <= sp_up_val;
  end

endmodule

// File: rtl/scr_seq.sv
module scr_seq
  import scr_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 16,
  parameter int unsigned CW = IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  act_e            dec_act,
  input  logic [W-1:0]    dec_store,
  input  logic [AW-1:0]   dec_target,
  input  logic [CW-1:0]   cmd_f1,
  input  logic [AW-1:0]   sp,
  input  logic [AW-1:0]   sp_up_val,
  output logic            sp_dec,
  output logic            sp_up,
  output logic [CW:0]     up_amt,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [W-1:0]    mem_wdata,
  input  logic [W-1:0]    mem_rdata,
  output logic            pc_we,
  output logic [AW-1:0]   pc_new,
  output logic            rf_we,
  output logic [CW-1:0]   rf_idx,
  output logic [W-1:0]    rf_wdata,
  output logic            done
);

  state_e        st_q, st_d;
  act_e          act_q;
  logic [W-1:0]  store_q;
  logic [AW-1:0] tgt_q;
  logic [CW-1:0] f1_q;
  logic          take;

  assign cmd_ready = (st_q == ST_IDLE);
  assign take      = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      act_q   <= ACT_NONE;
      store_q <= '0;
      tgt_q   <= '0;
      f1_q    <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        act_q   <= dec_act;
        store_q <= dec_store;
        tgt_q   <= dec_target;
        f1_q    <= cmd_f1;
      end
    end
  end

  // POP moves up by one; RET moves up by the discard count plus one
  assign up_amt = (act_q == ACT_RET) ? ({1'b0, f1_q} + (CW+1)'(1)) : (CW+1)'(1);

  always_comb begin
    st_d      = st_q;
    sp_dec    = 1'b0;
    sp_up     = 1'b0;
    mem_addr  = sp;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = store_q;
    pc_we     = 1'b0;
    pc_new    = tgt_q;
    rf_we     = 1'b0;
    rf_idx    = f1_q;
    rf_wdata  = mem_rdata;
    done      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (take) st_d = ST_EXEC;
      end
      ST_EXEC: begin
        unique case (act_q)
          ACT_PUSH, ACT_CALL: begin
            mem_we = 1'b1;
            sp_dec = 1'b1;
            pc_we  = (act_q == ACT_CALL);
            done   = 1'b1;
            st_d   = ST_IDLE;
          end
          ACT_POP, ACT_RET: begin
            mem_addr = sp_up_val;
            mem_re   = 1'b1;
            sp_up    = 1'b1;
            st_d     = ST_RWAIT;
          end
          ACT_JMP: begin
            pc_we = 1'b1;
            done  = 1'b1;
            st_d  = ST_IDLE;
          end
          default: begin
            done = 1'b1;
            st_d = ST_IDLE;
          end
        endcase
      end
      ST_RWAIT: begin
        if (act_q == ACT_RET) begin
          pc_we  = 1'b1;
          pc_new = mem_rdata[AW-1:0];
        end else begin
          rf_we = 1'b1;
        end
        done = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/scr_unit.sv
module scr_unit
  import scr_pkg::*;
#(
  parameter int unsigned   W      = 32,
  parameter int unsigned   AW     = 16,
  parameter logic [AW-1:0] SP_TOP = 16'hFFF0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [6:0]      cmd_op,
  input  logic [7:0]      cmd_ext,
  input  logic [4:0]      cmd_f1,
  input  logic [W-1:0]    cmd_reg,
  input  logic [W-1:0]    cmd_imm,
  input  logic [AW-1:0]   cmd_pc,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [W-1:0]    mem_wdata,
  input  logic [W-1:0]    mem_rdata,
  output logic [AW-1:0]   sp_o,
  output logic            pc_we,
  output logic [AW-1:0]   pc_new,
  output logic            rf_we,
  output logic [4:0]      rf_idx,
  output logic [W-1:0]    rf_wdata,
  output logic            done
);

  localparam int unsigned CW = IDXW;

  act_e          dec_act;
  logic [W-1:0]  dec_store;
  logic [AW-1:0] dec_target;
  logic          sp_dec, sp_up;
  logic [CW:0]   up_amt;
  logic [AW-1:0] sp_up_val;

  scr_decode #(.W(W), .AW(AW)) u_dec (
    .op        (cmd_op),
    .ext       (cmd_ext),
    .reg_val   (cmd_reg),
    .imm_val   (cmd_imm),
    .pc_val    (cmd_pc),
    .act       (dec_act),
    .store_val (dec_store),
    .target    (dec_target)
  );

  scr_sp #(.AW(AW), .CW(CW), .SP_TOP(SP_TOP)) u_sp (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec       (sp_dec),
    .up        (sp_up),
    .up_amt    (up_amt),
    .sp        (sp_o),
    .sp_up_val (sp_up_val)
  );

  scr_seq #(.W(W), .AW(AW), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .dec_act    (dec_act),
    .dec_store  (dec_store),
    .dec_target (dec_target),
    .cmd_f1     (cmd_f1),
    .sp         (sp_o),
    .sp_up_val  (sp_up_val),
    .sp_dec     (sp_dec),
    .sp_up      (sp_up),
    .up_amt     (up_amt),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .pc_we      (pc_we),
    .pc_new     (pc_new),
    .rf_we      (rf_we),
    .rf_idx     (rf_idx),
    .rf_wdata   (rf_wdata),
    .done       (done)
  );

endmodule

// File: rtl/scr_unit_chk.sv
module scr_unit_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] sp_o,
  input logic          rf_we,
  input logic          pc_we,
  input logic          done
);

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r2_store_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == sp_o);

  a_r2_dec_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_o == $past(sp_o) - AW'(1));

  a_r4_sp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp_o == $past(mem_addr));

  a_r4_read_completes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> done && (rf_we || pc_we));

  a_r9_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind scr_unit scr_unit_chk #(.AW(AW)) i_scr_unit_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_addr  (mem_addr),
  .sp_o      (sp_o),
  .rf_we     (rf_we),
  .pc_we     (pc_we),
  .done      (done)
);

// File: tb/test_scr_unit.sv
`timescale 1ns/1ps
module test_scr_unit;

  localparam int unsigned   W   = 32;
  localparam int unsigned   AW  = 16;
  localparam logic [AW-1:0] TOP = 16'h00F0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [6:0]    cmd_op = '0;
  logic [7:0]    cmd_ext = '0;
  logic [4:0]    cmd_f1 = '0;
  logic [W-1:0]  cmd_reg = '0;
  logic [W-1:0]  cmd_imm = '0;
  logic [AW-1:0] cmd_pc = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_re;
  logic [W-1:0]  mem_wdata;
  logic [W-1:0]  mem_rdata = '0;
  logic [AW-1:0] sp_o;
  logic          pc_we;
  logic [AW-1:0] pc_new;
  logic          rf_we;
  logic [4:0]    rf_idx;
  logic [W-1:0]  rf_wdata;
  logic          done;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] esp;
  logic [W-1:0]  mem [0:255];

  always #2.5 clk = ~clk;

  scr_unit #(.W(W), .AW(AW), .SP_TOP(TOP)) i_scr_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_ext(cmd_ext), .cmd_f1(cmd_f1), .cmd_reg(cmd_reg),
    .cmd_imm(cmd_imm), .cmd_pc(cmd_pc), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sp_o(sp_o),
    .pc_we(pc_we), .pc_new(pc_new), .rf_we(rf_we), .rf_idx(rf_idx),
    .rf_wdata(rf_wdata), .done(done)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what,
                    input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  // present a command, wait for acceptance, return at the negedge of the execute cycle
  task automatic send(input logic [6:0] op, input logic [7:0] ext, input logic [4:0] f1,
                      input logic [W-1:0] rv, input logic [W-1:0] iv, input logic [AW-1:0] pc);
    @(negedge clk);
    cmd_op = op; cmd_ext = ext; cmd_f1 = f1;
    cmd_reg = rv; cmd_imm = iv; cmd_pc = pc;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_push(input string req, input logic [7:0] ext,
                         input logic [W-1:0] rv, input logic [W-1:0] iv, input logic [W-1:0] expv);
    send(7'd14, ext, 5'd0, rv, iv, 16'h0);
    eq(req, "push we", mem_we, 1'b1);
    eq(req, "push addr", mem_addr, esp);
    eq(req, "push data", mem_wdata, expv);
    eq(req, "push done", done, 1'b1);
    @(negedge clk);
    esp = esp - 1'b1;
    eq(req, "push sp after", sp_o, esp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    esp = TOP;
    eq("R1", "sp", sp_o, TOP);
    eq("R1", "ready", cmd_ready, 1'b1);
    eq("R1", "strobes", {done, mem_we, mem_re, pc_we, rf_we}, 5'b0);
  endtask

  task automatic t_push_pop;
    do_push("R2", 8'h00, 32'h1111_AAAA, 32'hDEAD_0000, 32'h1111_AAAA);
    do_push("R3", 8'h01, 32'h0BAD_0000, 32'h2222_BBBB, 32'h2222_BBBB);
    send(7'd15, 8'h00, 5'd7, '0, '0, '0);
    eq("R4", "pop re", mem_re, 1'b1);
    eq("R4", "pop addr", mem_addr, esp + 1'b1);
    eq("R4", "pop no done yet", done, 1'b0);
    @(negedge clk);
    esp = esp + 1'b1;
    eq("R4", "pop sp", sp_o, esp);
    eq("R4", "pop rf_we", rf_we, 1'b1);
    eq("R4", "pop idx", rf_idx, 5'd7);
    eq("R4", "pop data", rf_wdata, 32'h2222_BBBB);
    eq("R4", "pop done", done, 1'b1);
  endtask

  task automatic t_ret_discard;
    // stack: TOP holds 1111AAAA; push one more word, then return discarding one
    do_push("R3", 8'h01, '0, 32'h0000_0033, 32'h0000_0033);
    send(7'd12, 8'h00, 5'd1, '0, '0, '0);
    eq("R5", "ret re", mem_re, 1'b1);
    eq("R5", "ret addr", mem_addr, esp + 16'd2);
    @(negedge clk);
    esp = esp + 16'd2;
    eq("R5", "ret sp", sp_o, esp);
    eq("R5", "ret pc_we", {pc_we, done}, 2'b11);
    eq("R5", "ret pc", pc_new, 16'hAAAA);
  endtask

  task automatic t_call_ret(input string req, input logic [7:0] ext, input logic [AW-1:0] pc,
                            input logic [W-1:0] rv, input logic [W-1:0] iv,
                            input logic [AW-1:0] tgt, input logic [AW-1:0] retpc);
    send(7'd13, ext, 5'd0, rv, iv, pc);
    eq(req, "call we", mem_we, 1'b1);
    eq("R7", "call addr", mem_addr, esp);
    eq(req, "call return word", mem_wdata, 32'(retpc));
    eq("R7", "call pc", {pc_we, pc_new}, {1'b1, tgt});
    @(negedge clk);
    esp = esp - 1'b1;
    eq("R7", "call sp", sp_o, esp);
    send(7'd12, 8'h00, 5'd0, '0, '0, '0);
    eq("R5", "ret0 addr", mem_addr, esp + 1'b1);
    @(negedge clk);
    esp = esp + 1'b1;
    eq("R5", "ret0 pc", {pc_we, pc_new}, {1'b1, retpc});
    eq("R5", "ret0 sp", sp_o, esp);
  endtask

  task automatic t_jmp(input logic [7:0] ext, input logic [AW-1:0] tgt);
    send(7'd12, ext, 5'd0, 32'h0000_1234, 32'h0000_5678, 16'h0040);
    eq("R6", "jmp pc", {pc_we, pc_new, done}, {1'b1, tgt, 1'b1});
    eq("R6", "jmp no mem", {mem_we, mem_re}, 2'b00);
    @(negedge clk);
    eq("R6", "jmp sp", sp_o, esp);
  endtask

  task automatic t_other;
    send(7'd9, 8'hFF, 5'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0);
    eq("R10", "other done", done, 1'b1);
    eq("R10", "other quiet", {mem_we, mem_re, pc_we, rf_we}, 4'b0);
    @(negedge clk);
    eq("R10", "other sp", sp_o, esp);
    eq("R10", "other ready", cmd_ready, 1'b1);
  endtask

  task automatic t_busy;
    do_push("R2", 8'h00, 32'h0000_5A5A, '0, 32'h0000_5A5A);
    send(7'd15, 8'h00, 5'd3, '0, '0, '0);
    // hold a jump on the channel while the pop runs
    cmd_op = 7'd12; cmd_ext = 8'h05; cmd_f1 = 5'd9;
    cmd_reg = '0; cmd_imm = 32'h0000_0777; cmd_valid = 1'b1;
    eq("R9", "busy ready exec", cmd_ready, 1'b0);
    eq("R11", "single access", {mem_we, mem_re}, 2'b01);
    @(negedge clk);
    esp = esp + 1'b1;
    eq("R9", "busy ready wait", cmd_ready, 1'b0);
    eq("R9", "pop idx kept", rf_idx, 5'd3);
    eq("R9", "pop data kept", rf_wdata, 32'h0000_5A5A);
    eq("R9", "held jump not run", pc_we, 1'b0);
    @(negedge clk);
    eq("R11", "no second access", {mem_we, mem_re}, 2'b00);
    eq("R9", "ready after done", cmd_ready, 1'b1);
    @(negedge clk);
    cmd_valid = 1'b0;
    eq("R9", "held jump runs", {pc_we, pc_new}, {1'b1, 16'h0777});
    @(negedge clk);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_push_pop();
    t_ret_discard();
    t_call_ret("R8", 8'h03, 16'h0100, 32'h0000_0200, '0, 16'h0200, 16'h0100);
    t_call_ret("R8", 8'h07, 16'h0300, 32'h0000_0999, 32'h0000_0450, 16'h0450, 16'h0301);
    t_jmp(8'h01, 16'h1234);
    t_jmp(8'h05, 16'h5678);
    t_other();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule